// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block holds an 8-bit timer/counter and an 8-bit watchdog counter that share a single 8-bit prescaler. The timer counts either instruction-cycle ticks or edges on an external pin. The pin is resynchronised and the active edge is selectable. When the timer steps from 0xFF to 0x00 it raises a one-cycle overflow pulse that an interrupt controller can latch. The watchdog counts ticks from a separate slow oscillator. When it is enabled and wraps, it issues a one-cycle reset pulse.

One control bit decides which of the two counters uses the prescaler; the other counter then runs undivided. The three ratio bits map to a different divide table for each side. For the timer, code n divides by 2^(n+1), from 1:2 up to 1:256. For the watchdog, code n divides by 2^n, from 1:1 up to 1:128. How the prescaler is cleared depends on where it is assigned. On the timer side, a write to the timer clears it. On the watchdog side, the watchdog-clear and sleep instruction strobes clear it.

Top module: `tmr_wdt_unit`

## Requirements
- R1: After reset, `tmrValue` is 0x00 and both `tmrOverflow` and `wdtReset` are low.
- R2: With `srcExt`=0 and `preToWdt`=1, each clock cycle in which `cycleTick` is high adds one to `tmrValue`. The new value is visible after that clock edge.
- R3: With `srcExt`=1, the timer counts edges of `extPin` after a two-flop synchroniser: rising edges when `edgeFall`=0 and falling edges when `edgeFall`=1. A count shows on `tmrValue` three clock edges after the pin changes, and `cycleTick` has no effect on the timer.
- R4: With `preToWdt`=0, the timer advances once per 2^(`ratioSel`+1) source events, counted from the last prescaler clear.
- R5: A cycle with `tmrWrite` high loads `tmrWrData` into the timer, and the load wins over a count in the same cycle. When `preToWdt`=0, the write also clears the prescaler.
- R6: When a count takes the timer from 0xFF to 0x00, `tmrOverflow` is high for exactly the one cycle in which `tmrValue` reads 0x00. A load never raises it.
- R7: With `preToWdt`=0 and `wdtEnable`=1, the watchdog advances on every `wdtTick`. The 256th tick after a clear produces a `wdtReset` pulse one cycle long.
- R8: With `preToWdt`=1 and `wdtEnable`=1, the watchdog advances once per 2^`ratioSel` ticks of `wdtTick`, so `wdtReset` fires on tick 256·2^`ratioSel` after a clear.
- R9: `wdtClear` or `sleepCmd` restarts the watchdog count. When `preToWdt`=1, either strobe also clears the prescaler. Counting continues after `sleepCmd`.
- R10: While `wdtEnable`=0, the watchdog is held at zero and `wdtReset` stays low, whatever `wdtTick` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleTick | input | 1 | Instruction-cycle tick, one clock wide |
| extPin | input | 1 | External timer input, asynchronous |
| wdtTick | input | 1 | Watchdog oscillator tick, one clock wide |
| srcExt | input | 1 | Timer source: 0 cycle tick, 1 external pin |
| edgeFall | input | 1 | External edge: 0 rising, 1 falling |
| preToWdt | input | 1 | Prescaler owner: 0 timer, 1 watchdog |
| ratioSel | input | 3 | Prescaler ratio code |
| wdtEnable | input | 1 | Watchdog enable |
| tmrWrite | input | 1 | Timer write strobe |
| tmrWrData | input | 8 | Timer write data |
| wdtClear | input | 1 | Watchdog-clear instruction strobe |
| sleepCmd | input | 1 | Sleep instruction strobe |
| tmrValue | output | 8 | Current timer value |
| tmrOverflow | output | 1 | One-cycle pulse on timer wrap |
| wdtReset | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The timer is driven first by plain cycle ticks and then by pin transitions of each polarity. Extra cycle ticks are injected while the pin is selected, which separates source selection from edge selection. Prescaled runs use two ratios and stop one event short of, and then exactly at, each step. These runs tell a correct divider apart from an off-by-one divider and from one that ignores a clear on write. The watchdog is taken to its time-out with the prescaler assigned both ways, after clear and sleep strobes, and after being disabled. Each run stops one tick before the expected pulse, which tells the two ratio tables apart and also detects a clear that fails to reach the counter.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;
  // Strobes from the control module to the datapath, one set per clock.
  typedef struct packed {
    logic tmrLoad;  // load the timer from write data
    logic tmrStep;  // advance the timer by one
    logic wdtStep;  // advance the watchdog by one
    logic wdtClr;   // restart the watchdog
  } tw_strobe_t;
endpackage

// File: rtl/tmr_wdt_ctrl.sv
module tmr_wdt_ctrl
  import tmr_wdt_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleTick,
  input  logic             extPin,
  input  logic             wdtTick,
  input  logic             srcExt,
  input  logic             edgeFall,
  input  logic             preToWdt,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             tmrWrite,
  input  logic             wdtClear,
  input  logic             sleepCmd,
  output tw_strobe_t       strobes
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pinPipe;
  logic              pinNow, pinPrev, pinRise, pinFall, extEvt, tmrEvt;
  logic              preEvt, preFire, preClr;
  logic [PRE_W-1:0]  preCnt, tmrMask, wdtMask, activeMask;

  // Synchroniser stages plus one history flop for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPipe <= '0;
    else       pinPipe <= {pinPipe[PIPE_W-2:0], extPin};
  end

  assign pinNow  = pinPipe[SYNC_STAGES-1];
  assign pinPrev = pinPipe[SYNC_STAGES];
  assign pinRise = pinNow & ~pinPrev;
  assign pinFall = ~pinNow & pinPrev;
  assign extEvt  = edgeFall ? pinFall : pinRise;
  assign tmrEvt  = srcExt ? extEvt : cycleTick;

  // Divider masks: timer side 2^(code+1), watchdog side 2^code.
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      tmrMask[i] = (i <= int'(ratioSel));
      wdtMask[i] = (i <  int'(ratioSel));
    end
  end

  assign activeMask = preToWdt ? wdtMask : tmrMask;
  assign preEvt     = preToWdt ? wdtTick : tmrEvt;
  assign preFire    = preEvt && ((preCnt & activeMask) == activeMask);
  assign preClr     = preToWdt ? (wdtClear | sleepCmd) : tmrWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       preCnt <= '0;
    else if (preClr) preCnt <= '0;
    else if (preEvt) preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobes.tmrLoad = tmrWrite;
    strobes.tmrStep = preToWdt ? tmrEvt : preFire;
    strobes.wdtStep = preToWdt ? preFire : wdtTick;
    strobes.wdtClr  = wdtClear | sleepCmd;
  end

  // R5: a timer write clears the prescaler while the timer owns it
  p_pre_clear_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tmrWrite && !preToWdt) |=> (preCnt == '0));

  // R9: clear or sleep clears the prescaler while the watchdog owns it
  p_pre_clear_wdt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (preToWdt && (wdtClear || sleepCmd)) |=> (preCnt == '0));
endmodule

// File: rtl/tmr_wdt_datapath.sv
module tmr_wdt_datapath
  import tmr_wdt_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tw_strobe_t       strobes,
  input  logic [TMR_W-1:0] loadData,
  input  logic             wdtEn,
  output logic [TMR_W-1:0] tmrVal,
  output logic             tmrOvf,
  output logic             wdtRst
);
  localparam logic [TMR_W-1:0] TMR_TOP = '1;
  localparam logic [WDT_W-1:0] WDT_TOP = '1;

  logic [WDT_W-1:0] wdtCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrVal <= '0;
      tmrOvf <= 1'b0;
    end else if (strobes.tmrLoad) begin
      tmrVal <= loadData;
      tmrOvf <= 1'b0;
    end else if (strobes.tmrStep) begin
      tmrVal <= tmrVal + 1'b1;
      tmrOvf <= (tmrVal == TMR_TOP);
    end else begin
      tmrOvf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtCnt <= '0;
      wdtRst <= 1'b0;
    end else if (!wdtEn || strobes.wdtClr) begin
      wdtCnt <= '0;
      wdtRst <= 1'b0;
    end else if (strobes.wdtStep) begin
      wdtCnt <= wdtCnt + 1'b1;
      wdtRst <= (wdtCnt == WDT_TOP);
    end else begin
      wdtRst <= 1'b0;
    end
  end

  // R6: overflow only on the cycle showing zero, right after 0xFF
  p_ovf_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |-> (tmrVal == '0 && $past(tmrVal) == TMR_TOP));

  // R5: a load shows the written data on the next cycle
  p_load_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tmrLoad |=> (tmrVal == $past(loadData)));

  // R7: the watchdog pulse lasts a single cycle
  p_wdt_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |=> !wdtRst);

  // R10: no pulse follows a disabled cycle
  p_wdt_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wdtEn |=> !wdtRst);
endmodule

// File: rtl/tmr_wdt_unit.sv
module tmr_wdt_unit
  import tmr_wdt_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int WDT_W = 8,
  parameter int PRE_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleTick,
  input  logic             extPin,
  input  logic             wdtTick,
  input  logic             srcExt,
  input  logic             edgeFall,
  input  logic             preToWdt,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             wdtEnable,
  input  logic             tmrWrite,
  input  logic [TMR_W-1:0] tmrWrData,
  input  logic             wdtClear,
  input  logic             sleepCmd,
  output logic [TMR_W-1:0] tmrValue,
  output logic             tmrOverflow,
  output logic             wdtReset
);
  tw_strobe_t strobes;

  tmr_wdt_ctrl #(.PRE_W(PRE_W), .SEL_W(SEL_W), .SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .extPin(extPin),
    .wdtTick(wdtTick), .srcExt(srcExt), .edgeFall(edgeFall),
    .preToWdt(preToWdt), .ratioSel(ratioSel), .tmrWrite(tmrWrite),
    .wdtClear(wdtClear), .sleepCmd(sleepCmd), .strobes(strobes)
  );

  tmr_wdt_datapath #(.TMR_W(TMR_W), .WDT_W(WDT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadData(tmrWrData),
    .wdtEn(wdtEnable), .tmrVal(tmrValue), .tmrOvf(tmrOverflow),
    .wdtRst(wdtReset)
  );
endmodule

// File: tb/tb_tmr_wdt_unit.sv
module tb_tmr_wdt_unit;
  logic       clk = 0, rstN = 0;
  logic       cycleTick = 0, extPin = 0, wdtTick = 0;
  logic       srcExt = 0, edgeFall = 0, preToWdt = 1;
  logic [2:0] ratioSel = 0;
  logic       wdtEnable = 0, tmrWrite = 0, wdtClear = 0, sleepCmd = 0;
  logic [7:0] tmrWrData = 0;
  logic [7:0] tmrValue;
  logic       tmrOverflow, wdtReset;

  int checks = 0, failures = 0, pulses = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tmr_wdt_unit dut (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .extPin(extPin),
    .wdtTick(wdtTick), .srcExt(srcExt), .edgeFall(edgeFall),
    .preToWdt(preToWdt), .ratioSel(ratioSel), .wdtEnable(wdtEnable),
    .tmrWrite(tmrWrite), .tmrWrData(tmrWrData), .wdtClear(wdtClear),
    .sleepCmd(sleepCmd), .tmrValue(tmrValue), .tmrOverflow(tmrOverflow),
    .wdtReset(wdtReset)
  );

  always @(negedge clk) if (rstN && wdtReset) pulses++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cycleTick = 1;
      @(negedge clk) cycleTick = 0;
    end
  endtask

  task automatic wdTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wdtTick = 1;
      @(negedge clk) wdtTick = 0;
    end
    @(negedge clk);
  endtask

  task automatic writeTmr(logic [7:0] v);
    @(negedge clk) begin tmrWrite = 1; tmrWrData = v; end
    @(negedge clk) tmrWrite = 0;
  endtask

  task automatic strobeClear(bit useSleep);
    @(negedge clk) if (useSleep) sleepCmd = 1; else wdtClear = 1;
    @(negedge clk) begin sleepCmd = 0; wdtClear = 0; end
  endtask

  task automatic pinTo(logic v);
    @(negedge clk) extPin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 timer", tmrValue, 0);
    check("R1 overflow", tmrOverflow, 0);
    check("R1 wdtReset", wdtReset, 0);
  endtask

  task automatic testInternal();
    preToWdt = 1; srcExt = 0;
    writeTmr(8'd0);
    cycTicks(5);
    check("R2 five ticks", tmrValue, 5);
    @(negedge clk) begin cycleTick = 1; tmrWrite = 1; tmrWrData = 8'd40; end
    @(negedge clk) begin cycleTick = 0; tmrWrite = 0; end
    check("R5 write wins over count", tmrValue, 40);
  endtask

  task automatic testExternal();
    preToWdt = 1; srcExt = 1; edgeFall = 0; extPin = 0;
    repeat (4) @(negedge clk);
    writeTmr(8'd0);
    for (int i = 0; i < 3; i++) begin pinTo(1); pinTo(0); end
    check("R3 rising edges", tmrValue, 3);
    cycTicks(4);
    check("R3 cycle tick ignored", tmrValue, 3);
    @(negedge clk) extPin = 1;
    @(negedge clk); @(negedge clk);
    check("R3 sync latency before", tmrValue, 3);
    @(negedge clk);
    check("R3 sync latency after", tmrValue, 4);
    repeat (2) @(negedge clk);
    edgeFall = 1;
    writeTmr(8'd0);
    pinTo(0); pinTo(1); pinTo(0);
    check("R3 falling edges", tmrValue, 2);
    srcExt = 0; edgeFall = 0;
  endtask

  task automatic testPrescaleTimer();
    preToWdt = 0; srcExt = 0; ratioSel = 3'd1;
    writeTmr(8'd0);
    cycTicks(3);
    check("R4 1:4 short", tmrValue, 0);
    cycTicks(1);
    check("R4 1:4 step", tmrValue, 1);
    cycTicks(4);
    check("R4 1:4 second", tmrValue, 2);
    cycTicks(2);
    writeTmr(8'd10);
    cycTicks(3);
    check("R5 prescaler cleared by write", tmrValue, 10);
    cycTicks(1);
    check("R5 step after clear", tmrValue, 11);
    ratioSel = 3'd7;
    writeTmr(8'd0);
    cycTicks(255);
    check("R4 1:256 short", tmrValue, 0);
    cycTicks(1);
    check("R4 1:256 step", tmrValue, 1);
    ratioSel = 3'd0;
    preToWdt = 1;
  endtask

  task automatic testOverflow();
    preToWdt = 1; srcExt = 0;
    writeTmr(8'hFF);
    check("R6 load raises nothing", tmrOverflow, 0);
    writeTmr(8'hFE);
    @(negedge clk) cycleTick = 1;
    @(negedge clk) cycleTick = 0;
    check("R6 at FF", tmrOverflow, 0);
    @(negedge clk) cycleTick = 1;
    @(negedge clk) cycleTick = 0;
    check("R6 value zero", tmrValue, 0);
    check("R6 pulse high", tmrOverflow, 1);
    @(negedge clk);
    check("R6 pulse one cycle", tmrOverflow, 0);
  endtask

  task automatic testWatchdog();
    int base;
    wdtEnable = 1; preToWdt = 0;
    strobeClear(0);
    base = pulses;
    wdTicks(255);
    check("R7 no pulse at 255", pulses - base, 0);
    wdTicks(1);
    check("R7 pulse at 256", pulses - base, 1);
    preToWdt = 1; ratioSel = 3'd1;
    strobeClear(0);
    base = pulses;
    wdTicks(511);
    check("R8 1:2 no pulse at 511", pulses - base, 0);
    wdTicks(1);
    check("R8 1:2 pulse at 512", pulses - base, 1);
    preToWdt = 0;
    strobeClear(0);
    wdTicks(200);
    strobeClear(0);
    base = pulses;
    wdTicks(255);
    check("R9 clear restarts", pulses - base, 0);
    wdTicks(1);
    check("R9 pulse after clear", pulses - base, 1);
    preToWdt = 1;
    strobeClear(0);
    wdTicks(301);
    strobeClear(1);
    base = pulses;
    wdTicks(511);
    check("R9 sleep clears both", pulses - base, 0);
    wdTicks(1);
    check("R9 counts on after sleep", pulses - base, 1);
  endtask

  task automatic testDisabled();
    int base;
    preToWdt = 0; wdtEnable = 0;
    base = pulses;
    wdTicks(300);
    check("R10 no pulse when off", pulses - base, 0);
    wdtEnable = 1;
    wdTicks(255);
    check("R10 held at zero", pulses - base, 0);
    wdTicks(1);
    check("R10 pulse after enable", pulses - base, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testInternal();
    testExternal();
    testPrescaleTimer();
    testOverflow();
    testWatchdog();
    testDisabled();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule